// File: doc/BRIEF.md
# Frame-Sync Interrupt Controller

This block turns phase strobes from a video timing generator into a single level interrupt for software. Each of the four frame phases arrives as a one-cycle strobe: back porch, vsync, active start and front porch. Two independent selectors each pick one of these phases. A strobe on any selected phase sets a sticky pending bit.

Software reaches the block over a simple synchronous register bus. A control word holds a global enable, a frame enable and the two selector fields. A status word exposes the pending bit, which is cleared by writing a one to it. The interrupt line follows the pending bit only while both enables are set. The pending bit always records events, so software can poll it with the line masked.

Top module: `fsi_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0 and irq_o is low.
- R2: A write to address 0 stores the control word, which reads back unchanged: bit 0 global enable, bit 1 frame enable, bits 3:2 selector A, bits 5:4 selector B. Higher bits read 0. The control word changes only on a write to address 0.
- R3: Selector A picks one phase strobe by index: 0 back porch, 1 vsync, 2 active start, 3 front porch. A strobe on the selected phase sets the pending bit (status bit 0) at the next clock edge. A strobe on any other phase has no effect, unless selector B selects that phase.
- R4: Selector B picks a phase with the same indices 0 to 2, and a strobe on that phase sets the pending bit. The value 3 selects no event, so a front-porch strobe does not set the pending bit through selector B.
- R5: The pending bit is set by a selected event even when both enables are 0.
- R6: irq_o is high exactly when the pending bit, the global enable and the frame enable are all 1.
- R7: Writing status (address 1) with bit 0 set clears the pending bit at that edge. Writing it with bit 0 clear leaves the pending bit unchanged.
- R8: A selected event in the same cycle as a clearing write leaves the pending bit set.
- R9: Writing 0 to both enables drops irq_o right after that edge, and the pending bit stays set.
- R10: Writes to addresses 2 and 3 change no state, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_i | input | 4 | One-cycle phase strobes, indexed by phase code |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt line |

## Verification
Register writes and phase strobes both act at the clock edge where they are sampled. The control word, the pending bit and irq_o therefore all show their new values in the cycle that follows that edge. Read data is combinational from the registers, so no read pipeline delay applies. The bench drives each stimulus on a falling edge and removes it on the next falling edge, which puts exactly one rising edge in between. It then samples rdata_o and irq_o at that second falling edge, one settled cycle after the edge that updated them.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int SEL_W  = 2;
  localparam int NUM_PH = 1 << SEL_W;
  localparam int NUM_SEL = 2;

  localparam logic [SEL_W-1:0] PH_BPORCH = 2'd0;
  localparam logic [SEL_W-1:0] PH_VSYNC  = 2'd1;
  localparam logic [SEL_W-1:0] PH_ACTIVE = 2'd2;
  localparam logic [SEL_W-1:0] PH_FPORCH = 2'd3;
  localparam logic [SEL_W-1:0] SEL_NONE  = 2'd3;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;

  typedef struct packed {
    logic [SEL_W-1:0] sel_b;
    logic [SEL_W-1:0] sel_a;
    logic             frame_en;
    logic             glob_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/fsi_ctrl_reg.sv
module fsi_ctrl_reg
  import fsi_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  ctrl_t        d_i,
  output ctrl_t        q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/fsi_event_sel.sv
module fsi_event_sel
  import fsi_pkg::*;
#(
  parameter bit HAS_NONE = 1'b0
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [NUM_PH-1:0] phase_i,
  output logic              hit_o
);
  logic muted;
  generate
    if (HAS_NONE) begin : g_none
      assign muted = (sel_i == SEL_NONE);
    end else begin : g_full
      assign muted = 1'b0;
    end
  endgenerate

  assign hit_o = phase_i[sel_i] & ~muted;
endmodule

// File: rtl/fsi_pend.sv
module fsi_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= set_i | (pend_o & ~clr_i);
  end
endmodule

// File: rtl/fsi_irq_ctrl.sv
module fsi_irq_ctrl
  import fsi_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PH-1:0] phase_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  ctrl_t ctrl_q;
  logic  ctrl_we, stat_clr, any_hit, pend_q;
  logic [NUM_SEL-1:0] sel_hit;
  logic [SEL_W-1:0]   sel_val [NUM_SEL];

  assign ctrl_we  = wr_en_i && (addr_i == A_CTRL);
  assign stat_clr = wr_en_i && (addr_i == A_STAT) && wdata_i[0];

  fsi_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we),
    .d_i    (ctrl_t'(wdata_i[CTRL_W-1:0])),
    .q_o    (ctrl_q)
  );

  assign sel_val[0] = ctrl_q.sel_a;
  assign sel_val[1] = ctrl_q.sel_b;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    fsi_event_sel #(.HAS_NONE(g != 0)) u_sel (
      .sel_i   (sel_val[g]),
      .phase_i (phase_i),
      .hit_o   (sel_hit[g])
    );
  end

  assign any_hit = |sel_hit;

  fsi_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (any_hit),
    .clr_i  (stat_clr),
    .pend_o (pend_q)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)      rdata_o[CTRL_W-1:0] = ctrl_q;
    else if (addr_i == A_STAT) rdata_o[0]          = pend_q;
  end

  assign irq_o = pend_q & ctrl_q.glob_en & ctrl_q.frame_en;
endmodule

// File: rtl/fsi_irq_ctrl_chk.sv
module fsi_irq_ctrl_chk
  import fsi_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              pend_q,
  input logic              any_hit,
  input ctrl_t             ctrl_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_CTRL) |=> $stable(ctrl_q));

  assert_rise_needs_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_hit |=> !$rose(pend_q));

  assert_sel_b_none_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && ctrl_q.sel_b == SEL_NONE && ctrl_q.sel_a != PH_FPORCH &&
     ctrl_q.sel_a != PH_BPORCH && ctrl_q.sel_a != PH_ACTIVE && !any_hit) |=> !pend_q);

  assert_irq_needs_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_q);

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_STAT && wdata_i[0] && !any_hit) |=> !pend_q);

  assert_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |=> pend_q);

  assert_disable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL && wdata_i[1:0] == 2'b00) |=> !irq_o);
endmodule

bind fsi_irq_ctrl fsi_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .pend_q  (pend_q),
  .any_hit (any_hit),
  .ctrl_q  (ctrl_q)
);

// File: tb/fsi_irq_ctrl_test.sv
module fsi_irq_ctrl_test;
  localparam int AW = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    phase = '0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsi_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one rising edge between drive and release
  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] ph = 4'h0);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; phase = ph;
    @(negedge clk);
    wr = 1'b0; wdata = '0; phase = '0;
  endtask

  task automatic pulse(input logic [3:0] ph);
    @(negedge clk);
    phase = ph;
    @(negedge clk);
    phase = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [DW-1:0] ctl(input bit ge, input bit fe, input int sa, input int sb);
    return DW'({sb[1:0], sa[1:0], fe, ge});
  endfunction

  task automatic t_reset;
    logic [DW-1:0] d;
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 stat", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_ctrl;
    logic [DW-1:0] d;
    wr_reg(0, 32'hFFFF_FF2D);
    rd(0, d); chk("R2 readback", d, 32'h2D);
    wr_reg(1, 32'h0);
    rd(0, d); chk("R2 hold on status write", d, 32'h2D);
    wr_reg(0, ctl(0, 0, 1, 3));
    rd(0, d); chk("R2 rewrite", d, 32'h34);
  endtask

  task automatic t_sel_a;
    logic [DW-1:0] d;
    for (int s = 0; s < 4; s++) begin
      wr_reg(0, ctl(0, 0, s, 3));
      wr_reg(1, 1);
      for (int p = 0; p < 3; p++) begin
        int o = (s + 1 + p) % 4;
        if (o != 3) begin
          pulse(4'b1 << o);
          rd(1, d); chk($sformatf("R3 sel_a=%0d other=%0d", s, o), d, 0);
        end
      end
      pulse(4'b1 << s);
      rd(1, d); chk($sformatf("R3 sel_a=%0d hit", s), d, 1);
      wr_reg(1, 1);
    end
  endtask

  task automatic t_sel_b;
    logic [DW-1:0] d;
    for (int s = 0; s < 3; s++) begin
      wr_reg(0, ctl(0, 0, 1, s));
      wr_reg(1, 1);
      pulse(4'b1 << s);
      rd(1, d); chk($sformatf("R4 sel_b=%0d hit", s), d, 1);
    end
    wr_reg(0, ctl(0, 0, 1, 3));
    wr_reg(1, 1);
    pulse(4'b1000);
    rd(1, d); chk("R4 sel_b none ignores fporch", d, 0);
    pulse(4'b0101);
    rd(1, d); chk("R4 sel_b none ignores others", d, 0);
  endtask

  task automatic t_poll;
    logic [DW-1:0] d;
    wr_reg(0, ctl(0, 0, 1, 3));
    wr_reg(1, 1);
    pulse(4'b0010);
    rd(1, d); chk("R5 pend while masked", d, 1);
    chk("R5 irq masked", irq, 0);
  endtask

  task automatic t_gate;
    for (int m = 0; m < 4; m++) begin
      wr_reg(0, ctl(m[0], m[1], 1, 3));
      chk($sformatf("R6 gate en=%0d pend=1", m), irq, (m == 3) ? 1 : 0);
    end
    wr_reg(1, 1);
    chk("R6 no pend no irq", irq, 0);
    pulse(4'b0010);
    chk("R6 event raises irq", irq, 1);
  endtask

  task automatic t_w1c;
    logic [DW-1:0] d;
    wr_reg(1, 32'hFFFF_FFFE);
    rd(1, d); chk("R7 write zero keeps", d, 1);
    wr_reg(1, 1);
    rd(1, d); chk("R7 write one clears", d, 0);
    chk("R7 irq drops", irq, 0);
  endtask

  task automatic t_race;
    logic [DW-1:0] d;
    pulse(4'b0010);
    wr_reg(1, 1, 4'b0010);
    rd(1, d); chk("R8 event beats clear", d, 1);
    wr_reg(1, 1, 4'b0010);
    wr_reg(1, 1);
    rd(1, d); chk("R8 later clear", d, 0);
  endtask

  task automatic t_disable;
    logic [DW-1:0] d;
    wr_reg(0, ctl(1, 1, 1, 3));
    pulse(4'b0010);
    chk("R9 irq before", irq, 1);
    wr_reg(0, ctl(0, 0, 1, 3));
    chk("R9 irq after disable", irq, 0);
    rd(1, d); chk("R9 pend kept", d, 1);
  endtask

  task automatic t_addr;
    logic [DW-1:0] d;
    wr_reg(2, 32'hFFFF_FFFF);
    wr_reg(3, 32'hFFFF_FFFF);
    rd(0, d); chk("R10 ctrl untouched", d, ctl(0, 0, 1, 3));
    rd(1, d); chk("R10 pend untouched", d, 1);
    rd(2, d); chk("R10 addr2 reads 0", d, 0);
    rd(3, d); chk("R10 addr3 reads 0", d, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ctrl;
    t_sel_a;
    t_sel_b;
    t_poll;
    t_gate;
    t_w1c;
    t_race;
    t_disable;
    t_addr;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule